// File: doc/BRIEF.md
# Baud Divisor Search Engine

This block picks the divisor pair for a two-stage baud generator: a clock divisor that scales the input clock, followed by a bit-period divisor. A host pulses `start_i` with a requested baud rate, the input clock frequency in hertz and a prescale-select bit. The engine then tries every allowed bit-period divisor in turn. For each one it works out the clock divisor and the rate that pair would actually give. It keeps the pair whose rate is closest to the request.

All divisions go through a single restoring divider inside the engine, which produces one quotient bit per cycle. After the last candidate the engine decides whether the best error is acceptable. It then pulses `done_o` and leaves the result on its outputs until the next search finishes. A search with the default parameters takes about 65 cycles for each candidate.

Top module: `baud_div_search`

## Requirements
- R1: A request is rejected without any search when the baud is zero or when twice the baud is greater than the input clock. `err_o` is then 1, and `cd_o` and `bdiv_o` are both 0.
- R2: When `pre_i` is 1, the effective clock used by the search is the input clock shifted right by 3 (divided by 8). The rejection test of R1 still uses the undivided input clock.
- R3: Each bit-period divisor d from DMIN up to DMAX is evaluated. For each one, cd = floor(ce / (baud·(d+1))) and rate = floor(ce / (cd·(d+1))), where ce is the effective clock. The error is the absolute difference between the baud and the rate, and the reported pair has the smallest error.
- R4: The best pair is replaced only when a candidate's error is strictly smaller. On equal error, the smallest d is kept.
- R5: A candidate whose cd is 0 is skipped. If every candidate is skipped, the result is `cd_o`=0 and `bdiv_o`=0 with `err_o`=1.
- R6: After the sweep, `err_o` is 1 exactly when floor(best_error·100 / baud) is greater than 3. The best pair is reported in either case.
- R7: `done_o` is high for exactly one cycle per accepted search. `cd_o`, `bdiv_o` and `err_o` change only in that cycle and hold at all other times.
- R8: `start_i` is ignored while `busy_o` is high. The running search completes with the inputs it captured.
- R9: `busy_o` rises the cycle after a start is accepted and stays high through the `done_o` cycle.
- R10: After reset, `busy_o`, `done_o`, `err_o`, `cd_o` and `bdiv_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a search; accepted only while idle |
| baud_i | input | W | Requested baud rate |
| fclk_i | input | W | Input clock frequency in Hz |
| pre_i | input | 1 | 1 = divide the input clock by 8 before the search |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected or best error above threshold |
| cd_o | output | W | Chosen clock divisor |
| bdiv_o | output | DW | Chosen bit-period divisor |

## Verification
The hardest situation to reach from the ports is a best error that sits right at the percentage threshold. Here the quotient floor(best_error·100/baud) is exactly 3, which must pass, or exactly 4, which must fail. These values depend on the whole sweep, so the bench cannot choose them directly. Instead it runs its arithmetic model over a grid of clock and baud values with no simulation time cost. It picks one request that lands on 3 and one that lands on 4, and only then drives those requests into the engine. Ties between candidates and sweeps where every candidate is skipped come from a reduced-range configuration. That configuration is swept over many clock, baud and prescale combinations.

// File: rtl/baud_div_search.sv
module baud_div_search #(
  parameter int W         = 32,
  parameter int DMIN      = 4,
  parameter int DMAX      = 254,
  parameter int PCT_MAX   = 3,
  parameter int PRE_SHIFT = 3,
  parameter int DW        = $clog2(DMAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  baud_i,
  input  logic [W-1:0]  fclk_i,
  input  logic          pre_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [W-1:0]  cd_o,
  output logic [DW-1:0] bdiv_o
);
  localparam int DVW = W + DW;
  localparam int CW  = $clog2(W);
  localparam int PW  = 2 * W + 8;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_DIV1, S_DIV2, S_CMP, S_FINAL, S_DONE} st_t;
  st_t st;

  logic [W-1:0]   baud_r, clk_e, cd_c, ach, best_err, best_cd;
  logic [DW-1:0]  d, best_d;
  logic           pre_r;
  logic [DVW-1:0] dvs;
  logic [DVW:0]   rem;
  logic [W-1:0]   qd;
  logic [CW-1:0]  cnt;

  logic [DVW:0]   rem_sh, rem_nx;
  logic [W-1:0]   qd_nx, ce_now, err_c;
  logic           ge, last_step, last_d, reject, too_big;
  logic [DVW-1:0] dvs_first, dvs_next, dvs_two;

  assign rem_sh    = {rem[DVW-1:0], qd[W-1]};
  assign ge        = rem_sh >= {1'b0, dvs};
  assign rem_nx    = ge ? rem_sh - {1'b0, dvs} : rem_sh;
  assign qd_nx     = {qd[W-2:0], ge};
  assign last_step = cnt == CW'(W - 1);
  assign last_d    = d == DW'(DMAX);

  assign ce_now    = pre_r ? (clk_e >> PRE_SHIFT) : clk_e;
  assign reject    = (baud_r == '0) || ({baud_r, 1'b0} > {1'b0, clk_e});
  assign dvs_first = DVW'(baud_r) * DVW'(DMIN + 1);
  assign dvs_next  = DVW'(baud_r) * (DVW'(d) + DVW'(2));
  assign dvs_two   = DVW'(qd_nx) * (DVW'(d) + DVW'(1));
  assign err_c     = (baud_r > ach) ? baud_r - ach : ach - baud_r;
  assign too_big   = (PW'(best_err) * PW'(100)) >= (PW'(baud_r) * PW'(PCT_MAX + 1));

  assign busy_o = st != S_IDLE;
  assign done_o = st == S_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      baud_r <= '0; clk_e <= '0; pre_r <= 1'b0;
      cd_c <= '0; ach <= '0; d <= '0;
      best_err <= '1; best_cd <= '0; best_d <= '0;
      dvs <= '0; rem <= '0; qd <= '0; cnt <= '0;
      err_o <= 1'b0; cd_o <= '0; bdiv_o <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          baud_r   <= baud_i;
          clk_e    <= fclk_i;
          pre_r    <= pre_i;
          best_err <= '1;
          best_cd  <= '0;
          best_d   <= '0;
          st       <= S_CHECK;
        end
        S_CHECK: if (reject) begin
          err_o  <= 1'b1;
          cd_o   <= '0;
          bdiv_o <= '0;
          st     <= S_DONE;
        end else begin
          clk_e <= ce_now;
          d     <= DW'(DMIN);
          qd    <= ce_now;
          rem   <= '0;
          cnt   <= '0;
          dvs   <= dvs_first;
          st    <= S_DIV1;
        end
        S_DIV1: begin
          rem <= rem_nx;
          qd  <= qd_nx;
          cnt <= cnt + 1'b1;
          if (last_step) begin
            rem <= '0;
            cnt <= '0;
            if (qd_nx == '0) begin
              if (last_d) st <= S_FINAL;
              else begin
                d   <= d + 1'b1;
                qd  <= clk_e;
                dvs <= dvs_next;
              end
            end else begin
              cd_c <= qd_nx;
              qd   <= clk_e;
              dvs  <= dvs_two;
              st   <= S_DIV2;
            end
          end
        end
        S_DIV2: begin
          rem <= rem_nx;
          qd  <= qd_nx;
          cnt <= cnt + 1'b1;
          if (last_step) begin
            ach <= qd_nx;
            st  <= S_CMP;
          end
        end
        S_CMP: begin
          if (err_c < best_err) begin
            best_err <= err_c;
            best_cd  <= cd_c;
            best_d   <= d;
          end
          if (last_d) st <= S_FINAL;
          else begin
            d   <= d + 1'b1;
            qd  <= clk_e;
            rem <= '0;
            cnt <= '0;
            dvs <= dvs_next;
            st  <= S_DIV1;
          end
        end
        S_FINAL: begin
          cd_o   <= best_cd;
          bdiv_o <= best_d;
          err_o  <= too_big;
          st     <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(cd_o) && $stable(bdiv_o) && $stable(err_o)));
  p_bdiv_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (bdiv_o >= DW'(DMIN) && bdiv_o <= DW'(DMAX)));
  p_cd_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (cd_o != '0));
  p_no_div0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIV1 || st == S_DIV2) |-> (dvs != '0));
  p_best_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIV1 || st == S_DIV2 || st == S_CMP) |=> (best_err <= $past(best_err)));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> ($stable(baud_r) && $stable(pre_r)));
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && reject) |=> (done_o && err_o && cd_o == '0));
endmodule

// File: tb/sim_baud_div_search.sv
module sim_baud_div_search;
  localparam int TCLK = 10;
  localparam int SW = 16, SDMIN = 4, SDMAX = 30;
  localparam int SDW = $clog2(SDMAX + 2);

  logic clk = 0, rst_n = 0;
  always #(TCLK/2) clk = ~clk;

  logic start = 0, pre = 0;
  logic [SW-1:0] baud = 0, fclk = 0;
  logic busy, done, err;
  logic [SW-1:0] cd;
  logic [SDW-1:0] bd;

  logic start2 = 0, pre2 = 0;
  logic [31:0] baud2 = 0, fclk2 = 0;
  logic busy2, done2, err2;
  logic [31:0] cd2;
  logic [7:0] bd2;

  int total = 0, fails = 0;

  baud_div_search #(.W(SW), .DMIN(SDMIN), .DMAX(SDMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .baud_i(baud), .fclk_i(fclk), .pre_i(pre),
    .busy_o(busy), .done_o(done), .err_o(err), .cd_o(cd), .bdiv_o(bd));

  baud_div_search u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start2), .baud_i(baud2), .fclk_i(fclk2), .pre_i(pre2),
    .busy_o(busy2), .done_o(done2), .err_o(err2), .cd_o(cd2), .bdiv_o(bd2));

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input longint b, input longint c, input bit p, input int w,
                       input int dmin, input int dmax,
                       output longint ocd, output longint obd, output bit oerr, output longint opct);
    longint ce, best, q, r, e;
    ocd = 0; obd = 0; opct = 0;
    if (b == 0 || 2 * b > c) begin oerr = 1; return; end
    ce = p ? c / 8 : c;
    best = (64'd1 << w) - 1;
    for (int k = dmin; k <= dmax; k++) begin
      q = ce / (b * (k + 1));
      if (q == 0) continue;
      r = ce / (q * (k + 1));
      e = (b > r) ? b - r : r - b;
      if (e < best) begin best = e; ocd = q; obd = k; end
    end
    opct = (best * 100) / b;
    oerr = opct > 3;
  endtask

  task automatic launch(input longint b, input longint c, input bit p);
    @(negedge clk);
    baud = SW'(b); fclk = SW'(c); pre = p; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run(input longint b, input longint c, input bit p, input string tag);
    longint ecd, ebd, epct; bit eerr, ok;
    model(b, c, p, SW, SDMIN, SDMAX, ecd, ebd, eerr, epct);
    launch(b, c, p);
    chk({tag, " R9 busy after start"}, busy, 1);
    wait_done(ok);
    chk({tag, " R7 done seen"}, ok, 1);
    chk({tag, " cd"}, cd, ecd);
    chk({tag, " bdiv"}, bd, ebd);
    chk({tag, " err"}, err, eerr);
    chk({tag, " R9 busy in done cycle"}, busy, 1);
    @(negedge clk);
    chk({tag, " R7 single pulse"}, done, 0);
    chk({tag, " R7 hold cd"}, cd, ecd);
    chk({tag, " R7 hold err"}, err, eerr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 err", err, 0);
    chk("R10 cd", cd, 0);
    chk("R10 bdiv", bd, 0);
    rst_n = 1;

    run(501, 1000, 0, "R1 over half");
    run(500, 1000, 0, "R1 exactly half");
    run(0, 1000, 0, "R1 zero baud");
    run(5000, 9000, 1, "R1 R2 checked before prescale");
    run(400, 1000, 1, "R5 all skipped");
    run(2400, 60000, 1, "R2 prescale");
    run(2400, 60000, 0, "R3 plain");

    for (int ci = 0; ci < 4; ci++) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k < 5; k++) begin
          longint cv;
          cv = (ci == 0) ? 1000 : (ci == 1) ? 4000 : (ci == 2) ? 50000 : 65535;
          run(cv / (k * 7 + 3) + k, cv, p[0], "R3 R4 R6 sweep");
        end
      end
    end

    begin
      bit f3 = 0, f4 = 0;
      longint b3 = 0, c3 = 0, b4 = 0, c4 = 0, xcd, xbd, xp; bit xe;
      for (int c = 20000; c <= 65000 && !(f3 && f4); c += 1500)
        for (int b = 200; b <= c / 2 && !(f3 && f4); b += 37) begin
          model(b, c, 0, SW, SDMIN, SDMAX, xcd, xbd, xe, xp);
          if (!f3 && xp == 3 && xcd != 0) begin f3 = 1; b3 = b; c3 = c; end
          if (!f4 && xp == 4 && xcd != 0) begin f4 = 1; b4 = b; c4 = c; end
        end
      if (f3) run(b3, c3, 0, "R6 pct 3 passes");
      if (f4) run(b4, c4, 0, "R6 pct 4 fails");
    end

    begin
      longint ecd, ebd, epct; bit eerr, ok;
      model(3000, 60000, 0, SW, SDMIN, SDMAX, ecd, ebd, eerr, epct);
      launch(3000, 60000, 0);
      repeat (40) @(negedge clk);
      baud = 700; fclk = 9000; pre = 1; start = 1;
      @(negedge clk);
      start = 0;
      chk("R8 still busy", busy, 1);
      wait_done(ok);
      chk("R8 cd from first request", cd, ecd);
      chk("R8 bdiv from first request", bd, ebd);
      chk("R8 err from first request", err, eerr);
      repeat (5) begin
        @(negedge clk);
        chk("R8 no second search", busy | done, 0);
      end
    end

    begin
      longint ecd, ebd, epct; bit eerr, ok;
      model(115200, 100000000, 0, 32, 4, 254, ecd, ebd, eerr, epct);
      @(negedge clk);
      baud2 = 115200; fclk2 = 100000000; pre2 = 0; start2 = 1;
      @(negedge clk);
      start2 = 0;
      for (int i = 0; i < 40000; i++) begin
        if (done2) begin ok = 1; break; end
        @(negedge clk);
      end
      chk("R3 full range done", ok, 1);
      chk("R3 full range cd", cd2, ecd);
      chk("R3 full range bdiv", bd2, ebd);
      chk("R6 full range err", err2, eerr);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired R7 actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule